// File: doc/BRIEF.md
# I2C Memory Target Write Front End

This block is the serial-bus target side of a 256-byte I2C memory, covering only the write path. It brings SCL and SDA into the system clock domain, finds START and STOP conditions, and shifts in the device address, the word address and the data bytes. It acknowledges each byte by pulling SDA low through an open-drain enable. The word address becomes an internal pointer. Every data byte the block acknowledges goes to a page write engine together with its address. A STOP that follows accepted bytes asks that engine to commit them.

While the engine reports a write cycle in progress, the block acknowledges nothing, not even its own device address. A host can therefore poll for the end of the cycle by repeating START plus the write address until it gets an ACK. A write-protect input guards the upper half of the memory. It is sampled once per transfer, just before the first data byte. A protected write is refused by leaving that data byte unacknowledged, and nothing is handed on. A repeated START in the middle of a transfer abandons it. The block then signals the engine to drop what it was given instead of committing it.

Top module: `i2c_wr_target`

## Requirements
- R1: After reset, `sda_oe`, `wr_valid`, `wr_commit` and `wr_drop` are all 0.
- R2: The block acknowledges a device-address byte only if it equals {DEV_ADDR, 0} (0xA0 with the default DEV_ADDR of 0x50, with R/W = 0 in bit 0). Any other byte, including the read form 0xA1, is not acknowledged, and every byte after it is ignored until the next START.
- R3: The block acknowledges the word-address byte and loads it into the pointer. The first data byte is reported with `wr_addr` equal to that word address.
- R4: `sda_oe` rises on the SCL falling edge that ends the eighth bit of an acknowledged byte. It falls on the SCL falling edge that ends the ninth clock.
- R5: Each acknowledged data byte produces a `wr_valid` pulse one cycle long, carrying `wr_addr` and `wr_data`. A STOP after at least one accepted byte gives exactly one `wr_commit` pulse.
- R6: After each accepted data byte, the low 4 pointer bits increment modulo 16 and the upper 4 bits stay unchanged. The 17th byte of a transfer therefore reuses the first byte's address.
- R7: While `busy_i` is 1, the device address is not acknowledged. Once `busy_i` is 0, the same address is acknowledged again.
- R8: `wp_i` is sampled on the SCL falling edge that ends the word-address acknowledge. If the sample is 1 and pointer bit 7 is 1, the first data byte is not acknowledged, and no `wr_valid` or `wr_commit` follows. Changes of `wp_i` after that edge have no effect on the transfer.
- R9: With `wp_i` at 0, or with a word address below 0x80, write protection has no effect and the data bytes are accepted.
- R10: A repeated START after accepted data bytes produces a `wr_drop` pulse and no `wr_commit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| wp_i | input | 1 | Write protect for the upper half |
| busy_i | input | 1 | Page write engine is in a write cycle |
| wr_valid | output | 1 | Accepted data byte strobe |
| wr_addr | output | 8 | Memory address of the accepted byte |
| wr_data | output | 8 | Accepted data byte |
| wr_commit | output | 1 | Commit the accepted bytes (on STOP) |
| wr_drop | output | 1 | Discard the accepted bytes (repeated START) |

## Verification
The bench targets the page-wrap boundary, where a design that carries into the upper pointer bits would send the 17th byte to the next page rather than back to the first byte's address. It moves the write-protect input on either side of its sampling edge. A block that samples too late or too often would then accept a protected write, or refuse a legal one. Acknowledge polling under busy checks that the block does not acknowledge its own address during a write cycle. A repeated START after data checks that an abandoned transfer is dropped instead of committed. The bench also checks that SDA is released once the ninth clock ends, so that a late release cannot corrupt the next data bit.

// File: rtl/i2c_wr_pkg.sv
package i2c_wr_pkg;

    localparam int BYTE_W  = 8;
    localparam int BIT_CNT = 4;

    typedef enum logic [2:0] {
        TS_IDLE,
        TS_DEV,
        TS_WADDR,
        TS_DATA,
        TS_IGNORE
    } tgt_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_evt_t;

    // Advance within a page: low PB bits wrap, upper bits are held.
    function automatic logic [BYTE_W-1:0] page_next(input logic [BYTE_W-1:0] p,
                                                     input int pb);
        logic [BYTE_W-1:0] mask;
        mask = BYTE_W'((1 << pb) - 1);
        return (p & ~mask) | ((p + 1'b1) & mask);
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic now_o,
    output logic prev_o
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-1:0], line_i};
    end

    assign now_o  = chain[STAGES-1];
    assign prev_o = chain[STAGES];
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events
    import i2c_wr_pkg::*;
(
    input  logic     scl_now,
    input  logic     scl_prev,
    input  logic     sda_now,
    input  logic     sda_prev,
    output bus_evt_t evt
);
    always_comb begin
        evt.scl_rise = scl_now & ~scl_prev;
        evt.scl_fall = ~scl_now & scl_prev;
        evt.start    = scl_now & scl_prev & sda_prev & ~sda_now;
        evt.stop     = scl_now & scl_prev & ~sda_prev & sda_now;
        evt.sda      = sda_now;
    end
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
    import i2c_wr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR  = 7'h50,
    parameter int         PAGE_BITS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic              wp_i,
    input  logic              busy_i,
    output logic              sda_oe,
    output logic              wr_valid,
    output logic [BYTE_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              wr_commit,
    output logic              wr_drop
);
    localparam logic [BIT_CNT-1:0] LAST_BIT = BIT_CNT'(BYTE_W);
    localparam logic [BIT_CNT-1:0] ACK_CLK  = BIT_CNT'(BYTE_W + 1);

    tgt_state_e         state;
    logic [BIT_CNT-1:0] cnt;
    logic [BYTE_W-1:0]  shreg;
    logic [BYTE_W-1:0]  ptr;
    logic               prot;
    logic               pending;
    logic               ack_ok;
    logic               active;

    assign active = (state == TS_DEV) || (state == TS_WADDR) || (state == TS_DATA);

    always_comb begin
        unique case (state)
            TS_DEV:   ack_ok = !busy_i && (shreg == {DEV_ADDR, 1'b0});
            TS_WADDR: ack_ok = !busy_i;
            TS_DATA:  ack_ok = !busy_i && !prot;
            default:  ack_ok = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= TS_IDLE;
            cnt       <= '0;
            shreg     <= '0;
            ptr       <= '0;
            prot      <= 1'b0;
            pending   <= 1'b0;
            sda_oe    <= 1'b0;
            wr_valid  <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            wr_commit <= 1'b0;
            wr_drop   <= 1'b0;
        end else begin
            wr_valid  <= 1'b0;
            wr_commit <= 1'b0;
            wr_drop   <= 1'b0;
            if (evt.start) begin
                state   <= TS_DEV;
                cnt     <= '0;
                sda_oe  <= 1'b0;
                wr_drop <= pending;
                pending <= 1'b0;
            end else if (evt.stop) begin
                state     <= TS_IDLE;
                sda_oe    <= 1'b0;
                wr_commit <= pending;
                pending   <= 1'b0;
            end else if (active) begin
                if (evt.scl_rise && cnt < LAST_BIT) begin
                    shreg <= {shreg[BYTE_W-2:0], evt.sda};
                    cnt   <= cnt + 1'b1;
                end else if (evt.scl_rise && cnt == LAST_BIT) begin
                    cnt <= ACK_CLK;
                end else if (evt.scl_fall && cnt == LAST_BIT) begin
                    if (!ack_ok) begin
                        state <= TS_IGNORE;
                    end else begin
                        sda_oe <= 1'b1;
                        if (state == TS_WADDR) ptr <= shreg;
                        if (state == TS_DATA) begin
                            wr_valid <= 1'b1;
                            wr_addr  <= ptr;
                            wr_data  <= shreg;
                            ptr      <= page_next(ptr, PAGE_BITS);
                            pending  <= 1'b1;
                        end
                    end
                end else if (evt.scl_fall && cnt == ACK_CLK) begin
                    sda_oe <= 1'b0;
                    cnt    <= '0;
                    if (state == TS_DEV)   state <= TS_WADDR;
                    if (state == TS_WADDR) begin
                        state <= TS_DATA;
                        prot  <= wp_i & ptr[BYTE_W-1];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/i2c_wr_target.sv
module i2c_wr_target
    import i2c_wr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         PAGE_BITS   = 4,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic       wp_i,
    input  logic       busy_i,
    output logic       wr_valid,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data,
    output logic       wr_commit,
    output logic       wr_drop
);
    logic     scl_now, scl_prev, sda_now, sda_prev;
    bus_evt_t evt;
    logic     scl_fall, start_det, stop_det;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst(rst), .line_i(scl_i), .now_o(scl_now), .prev_o(scl_prev)
    );
    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst(rst), .line_i(sda_i), .now_o(sda_now), .prev_o(sda_prev)
    );

    i2c_bus_events u_events (
        .scl_now(scl_now), .scl_prev(scl_prev),
        .sda_now(sda_now), .sda_prev(sda_prev), .evt(evt)
    );

    assign scl_fall  = evt.scl_fall;
    assign start_det = evt.start;
    assign stop_det  = evt.stop;

    i2c_target_fsm #(.DEV_ADDR(DEV_ADDR), .PAGE_BITS(PAGE_BITS)) u_fsm (
        .clk(clk), .rst(rst), .evt(evt), .wp_i(wp_i), .busy_i(busy_i),
        .sda_oe(sda_oe), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_commit(wr_commit), .wr_drop(wr_drop)
    );
endmodule

// File: rtl/i2c_wr_target_chk.sv
module i2c_wr_target_chk (
    input logic clk,
    input logic rst,
    input logic scl_fall,
    input logic start_det,
    input logic stop_det,
    input logic busy_i,
    input logic sda_oe,
    input logic wr_valid,
    input logic wr_commit,
    input logic wr_drop
);
    // R4: ACK drive starts only on an SCL falling edge
    p_ack_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> $past(scl_fall));

    // R4: release happens on an SCL fall or on a bus condition
    p_release_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_oe) |-> $past(scl_fall || start_det || stop_det));

    // R7: no acknowledge is started while the engine is busy
    p_busy_refuse_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !$past(busy_i));

    // R5: commit only follows a STOP
    p_commit_on_stop_r5: assert property (@(posedge clk) disable iff (rst)
        wr_commit |-> $past(stop_det));

    // R5: byte strobe lasts one cycle
    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> !wr_valid);

    // R10: drop only follows a START and never joins a commit
    p_drop_on_start_r10: assert property (@(posedge clk) disable iff (rst)
        wr_drop |-> ($past(start_det) && !wr_commit));
endmodule

bind i2c_wr_target i2c_wr_target_chk u_chk (
    .clk(clk), .rst(rst), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .busy_i(busy_i), .sda_oe(sda_oe),
    .wr_valid(wr_valid), .wr_commit(wr_commit), .wr_drop(wr_drop)
);

// File: tb/i2c_wr_target_tb.sv
`timescale 1ns/1ps
module i2c_wr_target_tb;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       wp = 1'b0;
    logic       busy = 1'b0;
    logic       sda_oe, wr_valid, wr_commit, wr_drop;
    logic [7:0] wr_addr, wr_data;
    logic       sda_line;

    int vectors = 0;
    int miscompares = 0;
    int n_wr = 0;
    int n_commit = 0;
    int n_drop = 0;
    logic [7:0] beat_addr [0:63];
    logic [7:0] beat_data [0:63];
    bit done = 1'b0;

    assign sda_line = sda_m & ~sda_oe;

    always #10 clk = ~clk;

    i2c_wr_target u_dut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .wp_i(wp), .busy_i(busy), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_commit(wr_commit), .wr_drop(wr_drop)
    );

    always @(posedge clk) begin
        if (!rst) begin
            if (wr_valid && n_wr < 64) begin
                beat_addr[n_wr] <= wr_addr;
                beat_data[n_wr] <= wr_data;
            end
            if (wr_valid)  n_wr     <= n_wr + 1;
            if (wr_commit) n_commit <= n_commit + 1;
            if (wr_drop)   n_drop   <= n_drop + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_cyc(Q);
        scl_m = 1'b1; wait_cyc(Q);
        sda_m = 1'b0; wait_cyc(Q);
        scl_m = 1'b0; wait_cyc(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_cyc(Q);
        scl_m = 1'b1; wait_cyc(Q);
        sda_m = 1'b1; wait_cyc(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_cyc(Q);
            scl_m = 1'b1; wait_cyc(2*Q);
            scl_m = 1'b0; wait_cyc(Q);
        end
        sda_m = 1'b1; wait_cyc(Q);
        scl_m = 1'b1; wait_cyc(Q);
        acked = !sda_line;
        wait_cyc(Q);
        scl_m = 1'b0; wait_cyc(Q);
        if (acked) chk(sda_oe == 1'b0, "R4 release after ninth clock", sda_oe, 0);
    endtask

    task automatic t_reset();
        chk(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
        chk(wr_valid == 1'b0 && wr_commit == 1'b0 && wr_drop == 1'b0, "R1 strobes",
            {wr_valid, wr_commit, wr_drop}, 0);
    endtask

    task automatic t_byte_write();
        bit a;
        int b0 = n_wr, c0 = n_commit;
        bus_start();
        send_byte(8'hA0, a); chk(a, "R2 device ack", a, 1);
        send_byte(8'h12, a); chk(a, "R3 word ack", a, 1);
        send_byte(8'hA5, a); chk(a, "R5 data ack", a, 1);
        bus_stop();
        chk(n_wr == b0 + 1, "R5 one beat", n_wr - b0, 1);
        chk(beat_addr[b0] == 8'h12, "R3 pointer", beat_addr[b0], 8'h12);
        chk(beat_data[b0] == 8'hA5, "R5 data", beat_data[b0], 8'hA5);
        chk(n_commit == c0 + 1, "R5 commit", n_commit - c0, 1);
    endtask

    task automatic t_bad_addr(input logic [7:0] dev);
        bit a;
        int b0 = n_wr, c0 = n_commit;
        bus_start();
        send_byte(dev, a);   chk(!a, "R2 foreign nack", a, 0);
        send_byte(8'h05, a); chk(!a, "R2 ignored word", a, 0);
        send_byte(8'h77, a); chk(!a, "R2 ignored data", a, 0);
        bus_stop();
        chk(n_wr == b0 && n_commit == c0, "R2 nothing written", n_wr - b0, 0);
    endtask

    task automatic t_page_wrap();
        bit a;
        int b0 = n_wr;
        logic [7:0] exp;
        bus_start();
        send_byte(8'hA0, a);
        send_byte(8'h3E, a);
        for (int k = 0; k < 18; k++) send_byte(8'h40 + 8'(k), a);
        bus_stop();
        chk(n_wr == b0 + 18, "R6 beat count", n_wr - b0, 18);
        for (int k = 0; k < 18; k++) begin
            exp = {4'h3, 4'(4'hE + k)};
            chk(beat_addr[b0+k] == exp, "R6 page address", beat_addr[b0+k], exp);
            chk(beat_data[b0+k] == 8'h40 + 8'(k), "R5 page data", beat_data[b0+k], 8'h40 + k);
        end
    endtask

    task automatic t_busy_poll();
        bit a;
        busy = 1'b1;
        bus_start(); send_byte(8'hA0, a); bus_stop();
        chk(!a, "R7 nack while busy", a, 0);
        busy = 1'b0;
        bus_start(); send_byte(8'hA0, a); bus_stop();
        chk(a, "R7 ack after busy", a, 1);
    endtask

    task automatic t_protect(input bit wp_before, input bit wp_after,
                             input logic [7:0] waddr, input bit expect_ok);
        bit a;
        int b0 = n_wr, c0 = n_commit;
        wp = wp_before;
        bus_start();
        send_byte(8'hA0, a);
        send_byte(waddr, a);
        wp = wp_after;
        send_byte(8'h5A, a);
        bus_stop();
        wp = 1'b0;
        if (expect_ok) begin
            chk(a, "R9 data accepted", a, 1);
            chk(n_wr == b0 + 1 && n_commit == c0 + 1, "R9 write kept", n_commit - c0, 1);
        end else begin
            chk(!a, "R8 data refused", a, 0);
            chk(n_wr == b0 && n_commit == c0, "R8 write rejected", n_wr - b0, 0);
        end
    endtask

    task automatic t_restart_abort();
        bit a;
        int c0 = n_commit, d0 = n_drop;
        bus_start();
        send_byte(8'hA0, a);
        send_byte(8'h20, a);
        send_byte(8'h11, a);
        bus_start();
        send_byte(8'hA0, a);
        chk(a, "R10 new transfer ack", a, 1);
        chk(n_drop == d0 + 1, "R10 drop", n_drop - d0, 1);
        bus_stop();
        chk(n_commit == c0, "R10 no commit", n_commit - c0, 0);
    endtask

    initial begin
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(5);
        t_reset();
        t_byte_write();
        t_bad_addr(8'hA4);
        t_bad_addr(8'hA1);
        t_page_wrap();
        t_busy_poll();
        t_protect(1'b1, 1'b0, 8'h90, 1'b0);
        t_protect(1'b0, 1'b1, 8'h90, 1'b1);
        t_protect(1'b1, 1'b1, 8'h10, 1'b1);
        t_restart_abort();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule